// File: doc/BRIEF.md
# Page-Buffered Flash Write Sequencer

This block is the device-side control logic of a byte-wide parallel flash memory. A host drives an asynchronous-style strobe bus (active-low chip enable, output enable and write enable, an 18-bit address and 8-bit data). The block collects byte loads into a 128-byte page buffer. It decides that a load phase is over when no further byte arrives within a byte-load timeout. It then runs a timed internal write cycle that replaces one whole page of a behavioural memory array. All timing runs on a free-running clock, and every duration is a parameter counted in clock cycles.

The bus has no ready or valid signal and cannot apply back-pressure. A byte strobe is either taken or silently dropped, and the host learns progress only by polling. While the internal cycle runs, any read returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the last byte loaded. Bit 6 flips on every new read. The host waits until two reads agree before it loads the next page. The behavioural array holds `ARRAY_PAGES` pages. Page numbers are folded onto it by their low bits, so two page numbers that share those bits address the same storage.

Top module: `pgflash_wseq`

## Requirements
- R1: A byte strobe is the span of cycles in which ce_n=0, we_n=0 and oe_n=1 all hold together. Cycles with oe_n=0, ce_n=1 or we_n=1 are never part of a strobe, and a byte is offered at the first clock after the span ends.
- R2: The address is taken in the first cycle of a strobe. The data is taken in the last cycle of the strobe. Address changes later in the strobe, and data values earlier in it, have no effect.
- R3: Address bits [17:7] give the page and bits [6:0] give the byte within it. The first accepted byte opens a load phase and fixes the page. Bytes for another page that arrive while the phase is open are dropped and do not restart the timeout.
- R4: Bytes may arrive in any order, and each accepted byte restarts the timeout. The internal write cycle starts TLOAD_CYC clocks after the last accepted byte, counted from the clock at which that byte was accepted.
- R5: The internal cycle lasts TPROG_CYC clocks. At its end, every byte of the page is replaced at once: loaded bytes take their loaded value and all other bytes become 8'hFF. Later reads return the new contents.
- R6: During the internal cycle, a read returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte, and bits 5:0 are 0.
- R7: During the internal cycle, bit 6 of the status byte is 1 on the first read and inverts at the start of each further read (onset of ce_n=0 with oe_n=0). After the cycle ends, reads return array data and no longer toggle.
- R8: A strobe of fewer than GLITCH_CYC clock samples is ignored.
- R9: No byte is accepted until pwr_good has been high for PWRUP_CYC clocks. A low pwr_good blocks writes and restarts the delay.
- R10: Strobes during the internal cycle are ignored: they change neither the page being written nor the cycle's timing.
- R11: dout_en is 1 exactly when ce_n=0 and oe_n=0. When dout_en is 0, dout is 8'h00.
- R12: After reset the block is idle, every array byte reads 8'hFF, and no load phase is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-valid indication, high when writes may be allowed |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 18 | Byte address: page in [17:7], byte in [6:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, 0 when not enabled |
| dout_en | output | 1 | High when the host may sample dout (bus driven) |

## Verification
On every cycle, the assertions check the following. An accepted byte always follows a strobe of at least the glitch length, and the power-up delay has elapsed. The load-to-program transition comes exactly one timeout after the last accepted same-page byte. The internal cycle has its full length and is never left for a load state. Within a held read, the polled bit 7 is stable, and bit 6 differs from one read to the next. Only the bench scenarios can show the data results. These are: which bytes end up in the array, FF fill of unloaded bytes, address and data capture points inside a strobe, dropping of foreign-page and busy-time writes, and the exact status values a host sees. A cycle-by-cycle reference model compares dout and dout_en against the design on every clock.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgf_state_e;

  // status byte seen by a host while the page is being committed
  function automatic logic [7:0] poll_byte(input logic last_b7, input logic tgl);
    return {~last_b7, tgl, 6'b00_0000};
  endfunction

endpackage

// File: rtl/pgf_bus_front.sv
module pgf_bus_front #(
  parameter int ADDR_W     = 18,
  parameter int GLITCH_CYC = 4,
  parameter int PWRUP_CYC  = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              byte_stb,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data,
  output logic              rd_start
);

  localparam int PW_W = $clog2(GLITCH_CYC + 1);
  localparam int PU_W = $clog2(PWRUP_CYC + 1);
  localparam logic [PW_W-1:0] PW_MAX = PW_W'(GLITCH_CYC);
  localparam logic [PU_W-1:0] PU_MAX = PU_W'(PWRUP_CYC);

  logic              wr_act, wr_act_q;
  logic              rd_act, rd_act_q;
  logic [PW_W-1:0]   pw_cnt;
  logic [PU_W-1:0]   pu_cnt;
  logic [ADDR_W-1:0] addr_lat;
  logic [7:0]        data_lat;
  logic              pu_ready;

  assign wr_act   = !ce_n && !we_n && oe_n;
  assign rd_act   = !ce_n && !oe_n;
  assign pu_ready = pwr_good && (pu_cnt == PU_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      pw_cnt   <= '0;
      pu_cnt   <= '0;
      addr_lat <= '0;
      data_lat <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (!wr_act)              pw_cnt <= '0;
      else if (pw_cnt != PW_MAX) pw_cnt <= pw_cnt + 1'b1;
      if (!pwr_good)             pu_cnt <= '0;
      else if (pu_cnt != PU_MAX) pu_cnt <= pu_cnt + 1'b1;
      if (wr_act && !wr_act_q) addr_lat <= addr;
      if (wr_act)              data_lat <= din;
    end
  end

  assign byte_stb  = !wr_act && wr_act_q && (pw_cnt == PW_MAX) && pu_ready;
  assign byte_addr = addr_lat;
  assign byte_data = data_lat;
  assign rd_start  = rd_act && !rd_act_q;

endmodule

// File: rtl/pgf_page_buf.sv
module pgf_page_buf #(
  parameter int PAGE_BYTES = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr,
  input  logic [$clog2(PAGE_BYTES)-1:0] idx,
  input  logic [7:0]                   wdata,
  output logic [PAGE_BYTES-1:0][7:0]   data_q,
  output logic [PAGE_BYTES-1:0]        valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= '0;
    end else begin
      if (clr) valid_q <= '0;
      if (wr) begin
        data_q[idx]  <= wdata;
        valid_q[idx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pgf_seq.sv
module pgf_seq
  import pgf_pkg::*;
#(
  parameter int PAGE_W    = 11,
  parameter int TLOAD_CYC = 150,
  parameter int TPROG_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [PAGE_W-1:0] byte_page,
  input  logic              byte_b7,
  input  logic              rd_start,
  output pgf_state_e        st,
  output logic [PAGE_W-1:0] page_q,
  output logic              last_b7,
  output logic              tgl,
  output logic              buf_clr,
  output logic              buf_wr,
  output logic              commit
);

  localparam int TM_W = $clog2(TLOAD_CYC + 1);
  localparam int PC_W = $clog2(TPROG_CYC + 1);
  localparam logic [TM_W-1:0] TM_END = TM_W'(TLOAD_CYC - 1);
  localparam logic [PC_W-1:0] PC_END = PC_W'(TPROG_CYC - 1);

  logic [TM_W-1:0] tmo_cnt;
  logic [PC_W-1:0] prg_cnt;
  logic            same_page;

  assign same_page = (byte_page == page_q);
  assign buf_clr   = byte_stb && (st == ST_IDLE);
  assign buf_wr    = byte_stb && ((st == ST_IDLE) || ((st == ST_LOAD) && same_page));
  assign commit    = (st == ST_PROG) && (prg_cnt == PC_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      page_q  <= '0;
      last_b7 <= 1'b0;
      tgl     <= 1'b0;
      tmo_cnt <= '0;
      prg_cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (buf_wr) begin
            page_q  <= byte_page;
            last_b7 <= byte_b7;
            tmo_cnt <= '0;
            st      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (buf_wr) begin
            last_b7 <= byte_b7;
            tmo_cnt <= '0;
          end else if (tmo_cnt == TM_END) begin
            st      <= ST_PROG;
            prg_cnt <= '0;
            tgl     <= 1'b0;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (rd_start) tgl <= ~tgl;
          if (commit) st <= ST_IDLE;
          else        prg_cnt <= prg_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgf_array.sv
module pgf_array #(
  parameter int PAGE_BYTES  = 128,
  parameter int ARRAY_PAGES = 16
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              commit,
  input  logic [$clog2(ARRAY_PAGES)-1:0]                    cpage,
  input  logic [PAGE_BYTES-1:0][7:0]                        cdata,
  input  logic [PAGE_BYTES-1:0]                             cvalid,
  input  logic [$clog2(ARRAY_PAGES)+$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [7:0]                                        rdata
);

  localparam int BIDX_W = $clog2(PAGE_BYTES);
  localparam int DEPTH  = ARRAY_PAGES * PAGE_BYTES;

  logic [7:0] mem [DEPTH];
  logic [PAGE_BYTES-1:0][7:0] fill;

  // per byte: loaded value or erased pattern
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_fill
    assign fill[b] = cvalid[b] ? cdata[b] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int b = 0; b < PAGE_BYTES; b++) mem[{cpage, BIDX_W'(b)}] <= fill[b];
    end
  end

  assign rdata = mem[rd_idx];

endmodule

// File: rtl/pgflash_wseq.sv
module pgflash_wseq
  import pgf_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PAGE_BYTES  = 128,
  parameter int ARRAY_PAGES = 16,
  parameter int GLITCH_CYC  = 4,
  parameter int TLOAD_CYC   = 150,
  parameter int TPROG_CYC   = 2500,
  parameter int PWRUP_CYC   = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  localparam int BIDX_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - BIDX_W;
  localparam int PIDX_W = $clog2(ARRAY_PAGES);

  logic              byte_stb, rd_start;
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        byte_data;
  pgf_state_e        st;
  logic [PAGE_W-1:0] page_q;
  logic              last_b7, tgl, buf_clr, buf_wr, commit;
  logic [PAGE_BYTES-1:0][7:0] buf_data;
  logic [PAGE_BYTES-1:0]      buf_valid;
  logic [7:0]        arr_rdata;

  pgf_bus_front #(
    .ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC), .PWRUP_CYC(PWRUP_CYC)
  ) u_front (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
    .byte_stb(byte_stb), .byte_addr(byte_addr), .byte_data(byte_data),
    .rd_start(rd_start)
  );

  pgf_seq #(
    .PAGE_W(PAGE_W), .TLOAD_CYC(TLOAD_CYC), .TPROG_CYC(TPROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb),
    .byte_page(byte_addr[ADDR_W-1:BIDX_W]), .byte_b7(byte_data[7]),
    .rd_start(rd_start), .st(st), .page_q(page_q), .last_b7(last_b7),
    .tgl(tgl), .buf_clr(buf_clr), .buf_wr(buf_wr), .commit(commit)
  );

  pgf_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
    .idx(byte_addr[BIDX_W-1:0]), .wdata(byte_data),
    .data_q(buf_data), .valid_q(buf_valid)
  );

  pgf_array #(.PAGE_BYTES(PAGE_BYTES), .ARRAY_PAGES(ARRAY_PAGES)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .cpage(page_q[PIDX_W-1:0]), .cdata(buf_data), .cvalid(buf_valid),
    .rd_idx(addr[BIDX_W+PIDX_W-1:0]), .rdata(arr_rdata)
  );

  assign dout_en = !ce_n && !oe_n;

  always_comb begin
    if (!dout_en)            dout = 8'h00;
    else if (st == ST_PROG)  dout = poll_byte(last_b7, tgl);
    else                     dout = arr_rdata;
  end

endmodule

// File: rtl/pgflash_wseq_chk.sv
module pgflash_wseq_chk
  import pgf_pkg::*;
#(
  parameter int GLITCH_CYC = 4,
  parameter int TLOAD_CYC  = 150,
  parameter int TPROG_CYC  = 2500,
  parameter int PWRUP_CYC  = 1250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic [1:0] dq_hi,
  input logic       dout_en,
  input pgf_state_e st,
  input logic       byte_stb,
  input logic       buf_wr
);

  int unsigned act_len, pu_len, quiet, pcnt;
  logic en_q, steady_q, prev_dq6, prev_vld;
  logic wact, steady, first_rd;

  assign wact     = !ce_n && !we_n && oe_n;
  assign steady   = dout_en && en_q;
  assign first_rd = steady && !steady_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len <= 0; pu_len <= 0; quiet <= 0; pcnt <= 0;
      en_q <= 1'b0; steady_q <= 1'b0; prev_dq6 <= 1'b0; prev_vld <= 1'b0;
    end else begin
      act_len <= !wact ? 0 : (act_len < GLITCH_CYC ? act_len + 1 : act_len);
      pu_len  <= !pwr_good ? 0 : (pu_len < PWRUP_CYC ? pu_len + 1 : pu_len);
      quiet   <= buf_wr ? 0 : (quiet < TLOAD_CYC ? quiet + 1 : quiet);
      pcnt    <= (st != ST_PROG) ? 0 : (pcnt < TPROG_CYC ? pcnt + 1 : pcnt);
      en_q     <= dout_en;
      steady_q <= steady;
      if (st != ST_PROG) prev_vld <= 1'b0;
      else if (first_rd) begin
        prev_dq6 <= dq_hi[0];
        prev_vld <= 1'b1;
      end
    end
  end

  p_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(!ce_n && !we_n && oe_n));
  p_glitch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> act_len >= GLITCH_CYC);
  p_powerup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> (pwr_good && pu_len >= PWRUP_CYC));
  p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && $past(st) == ST_LOAD) |-> $past(quiet) == TLOAD_CYC - 1);
  p_prog_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_PROG) |-> $past(pcnt) == TPROG_CYC - 1);
  p_busy_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st) == ST_PROG |-> st != ST_LOAD);
  p_dq7_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && st == ST_PROG && $past(st) == ST_PROG) |-> dq_hi[1] == $past(dq_hi[1]));
  p_dq6_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (first_rd && st == ST_PROG && prev_vld) |-> dq_hi[0] != prev_dq6);

endmodule

bind pgflash_wseq pgflash_wseq_chk #(
  .GLITCH_CYC(GLITCH_CYC), .TLOAD_CYC(TLOAD_CYC),
  .TPROG_CYC(TPROG_CYC), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .dq_hi(dout[7:6]), .dout_en(dout_en), .st(st),
  .byte_stb(byte_stb), .buf_wr(buf_wr)
);

// File: tb/pgflash_wseq_test.sv
`timescale 1ns/1ps
module pgflash_wseq_test;

  localparam int G  = 3;
  localparam int TL = 20;
  localparam int TP = 40;
  localparam int PU = 10;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pgflash_wseq #(
    .ADDR_W(18), .PAGE_BYTES(128), .ARRAY_PAGES(NP),
    .GLITCH_CYC(G), .TLOAD_CYC(TL), .TPROG_CYC(TP), .PWRUP_CYC(PU)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // ---------------- behavioural reference model ----------------
  bit m_wq, m_rq, m_tog;
  int m_pw, m_pu, m_al, m_dl, m_st, m_pg, m_last, m_tmo, m_pc;
  int m_buf[int];
  int m_mem[int];
  bit t_wact, t_ract, t_stb, t_rds;
  int t_sa, t_sd;

  function automatic int mem_rd(input int a);
    int k;
    k = (((a >> 7) % NP) * 128) + (a & 127);
    return m_mem.exists(k) ? m_mem[k] : 255;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wq = 0; m_rq = 0; m_tog = 0; m_pw = 0; m_pu = 0; m_al = 0; m_dl = 0;
      m_st = 0; m_pg = 0; m_last = 0; m_tmo = 0; m_pc = 0;
      m_buf.delete(); m_mem.delete();
    end else begin
      t_wact = !ce_n && !we_n && oe_n;
      t_ract = !ce_n && !oe_n;
      t_stb  = !t_wact && m_wq && (m_pw >= G) && pwr_good && (m_pu >= PU);
      t_rds  = t_ract && !m_rq;
      t_sa = m_al; t_sd = m_dl;
      if (t_wact && !m_wq) m_al = int'(addr);
      if (t_wact) m_dl = int'(din);
      m_pw = t_wact ? m_pw + 1 : 0;
      m_pu = pwr_good ? m_pu + 1 : 0;
      m_wq = t_wact; m_rq = t_ract;
      if (m_st == 0) begin
        if (t_stb) begin
          m_pg = t_sa >> 7; m_buf.delete(); m_buf[t_sa & 127] = t_sd;
          m_last = t_sd; m_tmo = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (t_stb && ((t_sa >> 7) == m_pg)) begin
          m_buf[t_sa & 127] = t_sd; m_last = t_sd; m_tmo = 0;
        end else if (m_tmo == TL - 1) begin
          m_st = 2; m_pc = 0; m_tog = 0;
        end else m_tmo++;
      end else begin
        if (t_rds) m_tog = !m_tog;
        if (m_pc == TP - 1) begin
          for (int i = 0; i < 128; i++)
            m_mem[((m_pg % NP) * 128) + i] = m_buf.exists(i) ? m_buf[i] : 255;
          m_st = 0;
        end else m_pc++;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      int e_en, e_d;
      e_en = (!ce_n && !oe_n) ? 1 : 0;
      if (e_en == 0) e_d = 0;
      else if (m_st == 2) e_d = ((m_last & 128) ? 0 : 128) | (m_tog ? 64 : 0);
      else e_d = mem_rd(int'(addr));
      n_chk++;
      if (int'(dout_en) != e_en || int'(dout) != e_d) begin
        n_fail++;
        $display("FAIL R6/R7/R11 cycle compare: actual en=%0d dout=%02h expected en=%0d dout=%02h",
                 dout_en, dout, e_en, e_d);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input int n);
    @(negedge clk);
    addr = 18'(a); din = 8'(d); ce_n = 0; we_n = 0; oe_n = 1;
    repeat (n) @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 18'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    v = int'(dout);
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 dout_en after reset", int'(dout_en), 0);
    chk("R11 dout idle", int'(dout), 0);
    rd(0, v);
    chk("R12 erased array", v, 8'hFF);

    // writes before the power-up delay is over
    pwr_good = 1;
    wr(128, 8'h12, 4);
    idle(TL + 5);
    rd(128, v);
    chk("R9 write inside power-up delay", v, 8'hFF);
    idle(PU);

    // short strobe and OE-low strobe
    wr(129, 8'h34, G - 1);
    @(negedge clk);
    addr = 18'd130; din = 8'h56; ce_n = 0; we_n = 0; oe_n = 0;
    repeat (5) @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
    idle(TL + 5);
    rd(129, v);
    chk("R8 glitch strobe dropped", v, 8'hFF);
    rd(130, v);
    chk("R1 OE-low strobe dropped", v, 8'hFF);

    // page 3, out of order, with a foreign page in the middle
    wr(384 + 5, 8'hA5, 4);
    idle(5);
    wr(384 + 2, 8'h3C, 4);
    idle(2);
    wr(7 * 128, 8'h77, 4);
    idle(2);
    wr(384 + 127, 8'h81, 4);
    idle(4);
    rd(384 + 5, v);
    chk("R4 still loading before timeout", v, 8'hFF);
    idle(TL);
    rd(384 + 127, v);
    chk("R6 poll first read", v, 8'h40);
    rd(384 + 127, v);
    chk("R7 poll second read toggles", v, 8'h00);
    wr(384 + 0, 8'h55, 4);
    rd(384 + 5, v);
    chk("R7 poll third read", v, 8'h40);
    idle(TP + 5);
    rd(384 + 5, v);   chk("R5 byte 5", v, 8'hA5);
    rd(384 + 2, v);   chk("R5 byte 2", v, 8'h3C);
    rd(384 + 127, v); chk("R5 byte 127", v, 8'h81);
    rd(384 + 10, v);  chk("R5 unloaded byte filled", v, 8'hFF);
    rd(384 + 0, v);   chk("R10 busy write dropped", v, 8'hFF);
    rd(7 * 128, v);   chk("R3 foreign page dropped", v, 8'hFF);
    rd(384 + 127, v); chk("R7 no toggle after done", v, 8'h81);

    // capture points inside one strobe
    @(negedge clk);
    addr = 18'(640 + 9); din = 8'h11; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    addr = 18'(640 + 10); din = 8'h22;
    @(negedge clk);
    din = 8'h6B;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 1;
    #1;
    chk("R11 no drive with OE high", int'(dout_en), 0);
    chk("R11 dout zero with OE high", int'(dout), 0);
    ce_n = 1;
    idle(TL + 2);
    rd(640 + 9, v);
    chk("R6 poll with bit7 clear", v, 8'hC0);
    idle(TP + 5);
    rd(640 + 9, v);
    chk("R2 last data at first address", v, 8'h6B);
    rd(640 + 10, v);
    chk("R2 later address ignored", v, 8'hFF);

    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule